// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the bus-side engine of a 16-bit core that reaches a 20-bit address space over shared pins. The low address bits and the data use one set of pins; the top address bits share pins with a small status field. Each transfer the core asks for becomes one bus cycle. The cycle runs through a fixed sequence of clock periods: an address period, a turnaround period, zero or more wait periods, a data period and a closing period. The sequencer produces the address-latch pulse, the read and write strobes, the data-buffer enable and direction, the memory/IO select and the pin float control.

On the core side, the request fields are held alongside `req_valid`. The sequencer takes a request only while it is idle or in the closing period. In the closing period it raises `ack` for one clock. On a read, `rd_data` holds the word sampled from the bus. A slow target stretches a cycle by holding `ready` low. Each low sample adds one whole clock period.

Top module: `mbc_bus_sequencer`

## Requirements
- R1: While and after reset, with no request, `ale`=0, `rd_n`=`wr_n`=`den_n`=1, `ad_oe`=0, `ack`=0, `dt_r`=0, `io_m`=0 and `req_rdy`=1.
- R2: In the first period after a request is taken (T1), `ale`=1 for exactly one clock and `ad_oe`=1. `ad_out` carries address bits [15:0] and `as_out` carries address bits [19:16].
- R3: From the second period (T2) until the cycle ends, `as_out` carries status instead of address. Bits 1:0 hold the segment code `req_seg`, bit 2 holds `req_ief` and bit 3 is 0.
- R4: On a read, `ad_oe`=0 from T2 through the closing period (T4). `rd_n` and `den_n` are 0 in T2, in every wait period and in T3, and 1 in T4. `wr_n` stays 1.
- R5: On a write, `ad_oe` stays 1 for the whole cycle and `ad_out` equals the write data from T2 through T4. `wr_n` is 0 from T2 through T3. In T4, `wr_n` is back at 1 while the data is still driven and `den_n` is still 0.
- R6: `ready` is sampled only at the clock edges that end T2 and end each wait period. Each low sample adds exactly one wait period, so a cycle with n low samples runs 4+n clocks from T1 to T4. `ready` is ignored at every other edge, including the edge that ends T3.
- R7: On a read, `rd_data` takes the value on `ad_in` at the edge that ends T3, which is the start of T4. It then holds that value until the next read.
- R8: `ack` is 1 only during T4, and never for two clocks in a row. `rd_n` and `wr_n` are never both 0.
- R9: `req_rdy` is 1 only when idle or in T4. A `req_valid` raised during T1, T2, a wait or T3 is ignored. A request present in T4 starts the next T1 on the very next clock.
- R10: `dt_r` is 1 for a write and 0 for a read. `io_m` is 1 for an I/O transfer and 0 for memory. Both are valid from T1 and stay constant through T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_seg | input | 2 | Segment code placed in status |
| req_ief | input | 1 | Interrupt-enable flag placed in status |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_rdy | output | 1 | Request can be taken this clock |
| ack | output | 1 | One-clock completion pulse (T4) |
| rd_data | output | 16 | Captured read word |
| ad_out | output | 16 | Shared address/data pins, driven value |
| ad_oe | output | 1 | Drive enable of shared pins (0 = floated) |
| ad_in | input | 16 | Shared address/data pins, received value |
| as_out | output | 4 | Upper address / status pins |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dt_r | output | 1 | Data buffer direction, 1 = transmit |
| io_m | output | 1 | Space select, 1 = I/O |
| ready | input | 1 | Target ready |

## Verification
The bench sweeps read and write, memory and I/O, and zero to three low ready samples. It counts the clocks to `ack` and checks every period's pins.

- A sequencer that samples ready at the wrong edge, or that skips or doubles a wait, gives the wrong cycle length.
- Read data is valid on `ad_in` only during T3, so capturing one clock early or late gives the wrong word.
- Ready is held low during T3; a design that obeys ready there stalls.
- Requests are raised mid-cycle with a different address. A design that takes them outside idle/T4 restarts the bus or corrupts the status.
- A request chained in T4 must start T1 with no idle gap.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4,
    PH_T4   = 3'd5
  } phase_t;

  typedef struct packed {
    logic       wr;
    logic       io;
    logic       ief;
    logic [1:0] seg;
  } ctl_t;

  // status field placed on the upper pins after T1: {0, ief, seg}
  function automatic logic [3:0] status_nibble(input ctl_t c);
    return {1'b0, c.ief, c.seg};
  endfunction

  function automatic logic in_strobe(input phase_t p);
    return (p == PH_T2) || (p == PH_TW) || (p == PH_T3);
  endfunction

  function automatic logic samples_ready(input phase_t p);
    return (p == PH_T2) || (p == PH_TW);
  endfunction

  function automatic logic can_accept(input phase_t p);
    return (p == PH_IDLE) || (p == PH_T4);
  endfunction

  function automatic logic data_phase(input phase_t p);
    return in_strobe(p) || (p == PH_T4);
  endfunction

endpackage

// File: rtl/mbc_phase_fsm.sv
module mbc_phase_fsm
  import mbc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   ready,
  output phase_t phase,
  output logic   accept,
  output logic   ready_look,
  output logic   wait_low
);

  phase_t nxt;

  assign ready_look = samples_ready(phase);
  assign accept     = req_valid && can_accept(phase);
  assign wait_low   = ready_look && !ready;

  always_comb begin
    case (phase)
      PH_IDLE: nxt = accept ? PH_T1 : PH_IDLE;
      PH_T1:   nxt = PH_T2;
      PH_T2,
      PH_TW:   nxt = ready ? PH_T3 : PH_TW;
      PH_T3:   nxt = PH_T4;
      PH_T4:   nxt = accept ? PH_T1 : PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  // T4 is reached only through T3
  p_t4_after_t3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_T4 |-> $past(phase) == PH_T3);

  // T1 is entered only for a taken request
  p_t1_from_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_T1 |-> $past(accept));

endmodule

// File: rtl/mbc_req_hold.sv
module mbc_req_hold
  import mbc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  ctl_t          req_ctl,
  output logic [AW-1:0] h_addr,
  output logic [DW-1:0] h_wdata,
  output ctl_t          h_ctl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_addr  <= '0;
      h_wdata <= '0;
      h_ctl   <= '0;
    end else if (accept) begin
      h_addr  <= req_addr;
      h_wdata <= req_wdata;
      h_ctl   <= req_ctl;
    end
  end

endmodule

// File: rtl/mbc_pin_drive.sv
module mbc_pin_drive
  import mbc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_t           phase,
  input  logic [AW-1:0]    h_addr,
  input  logic [DW-1:0]    h_wdata,
  input  ctl_t             h_ctl,
  input  logic [DW-1:0]    ad_in,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             den_n,
  output logic             dt_r,
  output logic             io_m,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [AW-DW-1:0] as_out,
  output logic [DW-1:0]    rd_data,
  output logic             ack
);

  localparam int HW = AW - DW;

  logic busy, strobe, capture;

  assign busy    = (phase != PH_IDLE);
  assign strobe  = in_strobe(phase);
  assign capture = (phase == PH_T3) && !h_ctl.wr;

  assign ale    = (phase == PH_T1);
  assign rd_n   = !(strobe && !h_ctl.wr);
  assign wr_n   = !(strobe && h_ctl.wr);
  assign den_n  = !(strobe || (phase == PH_T4 && h_ctl.wr));
  assign dt_r   = busy && h_ctl.wr;
  assign io_m   = busy && h_ctl.io;
  assign ad_oe  = ale || (h_ctl.wr && data_phase(phase));
  assign ad_out = ale ? h_addr[DW-1:0] : h_wdata;
  assign as_out = ale ? h_addr[AW-1:DW] : HW'(status_nibble(h_ctl));
  assign ack    = (phase == PH_T4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (capture) rd_data <= ad_in;
  end

  // read word equals the bus value at the start of T4
  p_capture_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T4 && !h_ctl.wr) |-> rd_data == $past(ad_in));

  // shared pins float for the whole data part of a read
  p_read_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

endmodule

// File: rtl/mbc_bus_sequencer.sv
module mbc_bus_sequencer
  import mbc_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_io,
  input  logic [1:0]       req_seg,
  input  logic             req_ief,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_rdy,
  output logic             ack,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic [AW-DW-1:0] as_out,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             den_n,
  output logic             dt_r,
  output logic             io_m,
  input  logic             ready
);

  phase_t        phase;
  logic          accept, ready_look, wait_low;
  ctl_t          req_ctl, h_ctl;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_wdata;

  assign req_ctl = '{wr: req_write, io: req_io, ief: req_ief, seg: req_seg};
  assign req_rdy = can_accept(phase);

  mbc_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
    .phase(phase), .accept(accept), .ready_look(ready_look), .wait_low(wait_low)
  );

  mbc_req_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ctl(req_ctl),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_ctl(h_ctl)
  );

  mbc_pin_drive #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_ctl(h_ctl), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r),
    .io_m(io_m), .ad_out(ad_out), .ad_oe(ad_oe), .as_out(as_out),
    .rd_data(rd_data), .ack(ack)
  );

  p_ale_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_wait_extends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_low |=> (!rd_n || !wr_n) && !ack);

  p_ready_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready_look |-> (!rd_n || !wr_n));

  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n || wr_n);

  p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_data_past_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe && ack && !den_n);

  p_dir_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> $stable(dt_r) && $stable(io_m));

endmodule

// File: tb/mbc_bus_sequencer_test.sv
module mbc_bus_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_ief = 1'b0;
  logic [1:0]  req_seg = 2'd0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] ad_in = '0;
  logic        ready = 1'b1;
  logic        req_rdy, ack, ad_oe, ale, rd_n, wr_n, den_n, dt_r, io_m;
  logic [15:0] rd_data, ad_out;
  logic [3:0]  as_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // next request to chain in T4
  bit          nx_valid = 0, nx_w = 0, nx_io = 0, nx_ief = 0;
  logic [1:0]  nx_seg = 0;
  logic [19:0] nx_addr = 0;
  logic [15:0] nx_data = 0;

  always #10 clk = ~clk;

  mbc_bus_sequencer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_seg(req_seg), .req_ief(req_ief), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_rdy(req_rdy), .ack(ack), .rd_data(rd_data),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .as_out(as_out), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r), .io_m(io_m),
    .ready(ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic drive_req(input bit w, input bit io, input logic [19:0] a,
                           input logic [15:0] d, input logic [1:0] sg, input bit ie);
    req_valid = 1; req_write = w; req_io = io; req_addr = a;
    req_wdata = d; req_seg = sg; req_ief = ie;
  endtask

  // one full transfer; n = number of low ready samples
  task automatic xfer(input bit w, input bit io, input logic [19:0] a,
                      input logic [15:0] d, input logic [1:0] sg, input bit ie,
                      input int n, input bit poke, input bit launched);
    logic [3:0] st;
    bit got;
    st = {1'b0, ie, sg};
    got = 0;
    if (!launched) begin
      @(negedge clk);
      drive_req(w, io, a, d, sg, ie);
    end
    ad_in = ~d;
    // T1
    @(negedge clk);
    chk(ale && ad_oe && ad_out == a[15:0], "R2 T1 address", {ale, ad_oe, ad_out}, {2'b11, a[15:0]});
    chk(as_out == a[19:16], "R2 upper address", as_out, a[19:16]);
    chk(dt_r == w && io_m == io, "R10 dir/space", {dt_r, io_m}, {w, io});
    chk(!req_rdy, "R9 busy in T1", req_rdy, 0);
    if (poke) drive_req(~w, ~io, ~a, ~d, ~sg, ~ie);
    else      req_valid = 0;
    // T2
    @(negedge clk);
    ready = (n == 0);
    chk(!ale && as_out == st, "R3 status", {ale, as_out}, {1'b0, st});
    if (w) chk(!wr_n && rd_n && ad_oe && ad_out == d && !den_n, "R5 write T2",
               {wr_n, rd_n, ad_oe, den_n, ad_out}, {4'b0110, d});
    else   chk(!rd_n && wr_n && !ad_oe && !den_n, "R4 read T2",
               {rd_n, wr_n, ad_oe, den_n}, 4'b0100);
    // waits, T3, T4
    for (int k = 0; k < n + 6; k++) begin
      @(negedge clk);
      if (ack) begin
        chk(k == n + 1, "R6 cycle length", k + 3, n + 4);
        got = 1;
        break;
      end
      chk(w ? (!wr_n && ad_out == d) : !rd_n, "R6 strobe held in wait/T3",
          {rd_n, wr_n}, {w, !w});
      chk(as_out == st && dt_r == w && io_m == io, "R3 R10 held",
          {as_out, dt_r, io_m}, {st, w, io});
      if (k == n) ad_in = d;
      ready = (k == n - 1);
      if (k == n) ready = 0;
    end
    if (!got) chk(0, "R6 no ack", 0, n + 4);
    // T4
    ad_in = ~d;
    chk(rd_n && wr_n, "R8 strobes off in T4", {rd_n, wr_n}, 2'b11);
    chk(req_rdy, "R9 ready in T4", req_rdy, 1);
    if (w) chk(ad_oe && ad_out == d && !den_n, "R5 data past strobe",
               {ad_oe, den_n, ad_out}, {2'b10, d});
    else   chk(rd_data == d && !ad_oe && den_n, "R7 R4 read capture",
               {ad_oe, den_n, rd_data}, {2'b01, d});
    if (nx_valid) begin
      drive_req(nx_w, nx_io, nx_addr, nx_data, nx_seg, nx_ief);
      nx_valid = 0;
    end else begin
      req_valid = 0;
      @(negedge clk);
      chk(!ale && !ack && req_rdy && rd_n && wr_n, "R9 R8 idle after T4",
          {ale, ack, req_rdy, rd_n, wr_n}, 5'b00111);
      if (!w) chk(rd_data == d, "R7 read word held", rd_data, d);
    end
    ready = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ale && rd_n && wr_n && den_n && !ad_oe && !ack && req_rdy,
        "R1 in reset", {ale, rd_n, wr_n, den_n, ad_oe, ack, req_rdy}, 7'b0111001);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!ale && rd_n && wr_n && den_n && !ad_oe && !ack && !dt_r && !io_m && req_rdy,
        "R1 idle", {ale, rd_n, wr_n, den_n, ad_oe, ack, dt_r, io_m, req_rdy},
        9'b011100001);

    for (int w = 0; w < 2; w++)
      for (int io = 0; io < 2; io++)
        for (int n = 0; n < 4; n++) begin
          logic [19:0] a;
          logic [15:0] d;
          a = 20'hA5C3E ^ (20'(w * 8 + io * 4 + n) * 20'h11111);
          d = 16'h3C96 + 16'(w * 977 + io * 311 + n * 53);
          xfer(w[0], io[0], a, d, n[1:0], w[0] ^ io[0], n, n == 2, 0);
        end

    // back-to-back: read then write chained in T4
    nx_valid = 1; nx_w = 1; nx_io = 0; nx_addr = 20'h0F00D; nx_data = 16'hBEEF;
    nx_seg = 2'd3; nx_ief = 1;
    xfer(0, 1, 20'hFFFF0, 16'h1234, 2'd1, 0, 1, 0, 0);
    xfer(1, 0, 20'h0F00D, 16'hBEEF, 2'd3, 1, 0, 0, 1);

    // ready low while idle has no effect
    ready = 0;
    repeat (3) @(negedge clk);
    chk(!ale && rd_n && wr_n && req_rdy, "R6 R9 idle ignores ready",
        {ale, rd_n, wr_n, req_rdy}, 4'b0111);
    ready = 1;
    finish_up();
  end

endmodule